// File: doc/BRIEF.md
# Prescaled Interrupt Counter with Selectable Clock Source

This block raises an interrupt after a programmed number of events. An 8-bit prescaler sits in front of an 8-bit main counter. Software sets the count direction, the prescaler width, the event source and the start values through a small group of write-only registers on the CPU bus. The event source is one of four inputs:
- a CPU-cycle pulse
- the graphics address line A12, of which only rising edges count
- a graphics-read pulse
- an external write pulse

Values loaded into the prescaler and the main counter are first XORed with a key that software writes beforehand. When the main counter wraps past its end value while the block is enabled, a sticky interrupt line goes high. It stays high until software acknowledges it.

Register writes are decoded from a 16-bit address. The address is masked with 0xF007 and compared against the page 0xC000. Address bits 11 to 3 are ignored, so each of the eight registers appears at many aliases. A write that hits the prescaler or counter load register in the same cycle as a source event takes priority, and that event is dropped.

Top module: `irq_prescale_counter`

## Requirements
- R1: Mode bits [1:0] select the event source: 0 = `cyc_tick`, 1 = rising edge of `a12_level`, 2 = `ppu_rd_tick`, 3 = `ext_wr_tick`. Events on the three unselected inputs leave the prescaler, the counter and `irq` unchanged.
- R2: The load registers work through the key, which is written at offset 6. A write at offset 4 sets the prescaler to data XOR key. A write at offset 5 sets the main counter to data XOR key.
- R3: When mode bit 2 is 1, only the low 3 bits of the prescaler are compared. When it is 0, all 8 bits are compared.
- R4: When mode bits [7:6] = 01 (count up), each selected event increments the prescaler. When the compared prescaler bits become all zero, the main counter increments. If that makes the counter 0x00 while enabled, `irq` goes high on the next clock edge and stays high until it is acknowledged.
- R5: A write at offset 0 sets the enable flag from data bit 0. If data bit 0 is 0, the write also clears `irq`.
- R6: A write at offset 2 clears both the enable flag and `irq`. While the block is disabled, a counter wrap does not raise `irq`.
- R7: A write at offset 3 sets the enable flag and leaves `irq` as it was.
- R8: When mode bits [7:6] = 10 (count down), each selected event decrements the prescaler. When the compared prescaler bits become all ones, the main counter decrements. If that makes the counter 0xFF while enabled, `irq` goes high.
- R9: When mode bits [7:6] are 00 or 11, both the prescaler and the main counter hold their values on every event.
- R10: Synchronous reset (`rst` high) clears the mode, key, enable flag, prescaler, counter and `irq`.
- R11: Level `a12_level` passes through a two-stage synchronizer. Only its rising edges are events. Holding the line high or pulling it low counts nothing.
- R12: A write is decoded only when (address AND 0xF007) equals 0xC000 + offset. A write that does not decode, and any write at offset 7, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cyc_tick | input | 1 | CPU-cycle event pulse |
| a12_level | input | 1 | Asynchronous graphics address line A12 |
| ppu_rd_tick | input | 1 | Graphics-read event pulse |
| ext_wr_tick | input | 1 | External write event pulse |
| irq | output | 1 | Registered, sticky interrupt request |

## Verification
The bound checker watches four things on every cycle:
- the acknowledge paths at offsets 0 and 2 always drop `irq` on the next cycle;
- `irq` never falls without an acknowledge;
- an offset-3 strobe keeps it high;
- it only rises while enabled, and the counter does not move in the two hold directions.

Only the bench scenarios can show the behaviours below, which it checks against a step model of the prescaler and counter:
- exactly which event makes the counter wrap, in each direction and with both prescaler widths;
- the effect of the XOR key on loads;
- that unselected sources are ignored;
- that A12 counts on edges rather than on level;
- that address aliases decode while other pages do not.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SRC_CYCLE = 2'd0,
    SRC_A12   = 2'd1,
    SRC_PPURD = 2'd2,
    SRC_EXTWR = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DIR_HOLD_LO = 2'd0,
    DIR_UP      = 2'd1,
    DIR_DOWN    = 2'd2,
    DIR_HOLD_HI = 2'd3
  } dir_e;

  typedef struct packed {
    dir_e   dir;
    logic   short_pre;
    src_e   src;
  } mode_t;

  // Register offsets inside the decoded page (offset 7 is accepted and ignored)
  localparam logic [2:0] OFS_ENA  = 3'd0;
  localparam logic [2:0] OFS_MODE = 3'd1;
  localparam logic [2:0] OFS_DIS  = 3'd2;
  localparam logic [2:0] OFS_ENS  = 3'd3;
  localparam logic [2:0] OFS_PRE  = 3'd4;
  localparam logic [2:0] OFS_CNT  = 3'd5;
  localparam logic [2:0] OFS_KEY  = 3'd6;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [3:0] PAGE = 4'hC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mode_t             mode,
  output logic              en,
  output logic              ld_pre,
  output logic              ld_cnt,
  output logic [DATA_W-1:0] ld_val,
  output logic              irq_clr
);

  logic [DATA_W-1:0] key_q;
  mode_t             mode_q;
  logic              en_q;
  logic              hit;
  logic [2:0]        ofs;
  logic              unused_addr;

  // R12: only the top nibble and the low three bits take part in decode
  assign hit         = wr_en && (wr_addr[ADDR_W-1 -: 4] == PAGE);
  assign ofs         = wr_addr[2:0];
  assign unused_addr = ^wr_addr[ADDR_W-5:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      mode_q <= '{dir: DIR_HOLD_LO, short_pre: 1'b0, src: SRC_CYCLE};
      en_q   <= 1'b0;
    end else if (hit) begin
      case (ofs)
        OFS_ENA:  en_q   <= wr_data[0];               // R5
        OFS_MODE: mode_q <= '{dir: dir_e'(wr_data[7:6]),
                              short_pre: wr_data[2],
                              src: src_e'(wr_data[1:0])};
        OFS_DIS:  en_q   <= 1'b0;                     // R6
        OFS_ENS:  en_q   <= 1'b1;                     // R7
        OFS_KEY:  key_q  <= wr_data;                  // R2
        default:  ;
      endcase
    end
  end

  assign mode    = mode_q;
  assign en      = en_q;
  assign ld_pre  = hit && (ofs == OFS_PRE);
  assign ld_cnt  = hit && (ofs == OFS_CNT);
  assign ld_val  = wr_data ^ key_q;
  assign irq_clr = hit && ((ofs == OFS_DIS) || ((ofs == OFS_ENA) && !wr_data[0]));

endmodule

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  src_e src,
  input  logic cyc_tick,
  input  logic a12_level,
  input  logic ppu_rd_tick,
  input  logic ext_wr_tick,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   a12_prev_q;
  logic                   a12_rise;

  // R11: synchronise the asynchronous line before edge detection
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= a12_level;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], a12_level};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) a12_prev_q <= 1'b0;
    else     a12_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign a12_rise = sync_q[SYNC_STAGES-1] && !a12_prev_q;

  // R1: one source feeds the chain
  always_comb begin
    case (src)
      SRC_CYCLE: tick = cyc_tick;
      SRC_A12:   tick = a12_rise;
      SRC_PPURD: tick = ppu_rd_tick;
      default:   tick = ext_wr_tick;
    endcase
  end

endmodule

// File: rtl/irqc_chain.sv
module irqc_chain
  import irqc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SHORT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  dir_e              dir,
  input  logic              short_pre,
  input  logic              en,
  input  logic              ld_pre,
  input  logic              ld_cnt,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] cnt,
  output logic              irq
);

  localparam logic [DATA_W-1:0] MASK_SHORT = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_FULL  = '1;

  logic [DATA_W-1:0] pre_q, cnt_q, pre_nx, cnt_nx, mask;
  logic              up, step, pre_hit, cnt_wrap;
  logic              irq_q;

  assign up     = (dir == DIR_UP);
  // R9: hold directions never step; a load in the same cycle drops the event
  assign step   = tick && (dir == DIR_UP || dir == DIR_DOWN) && !ld_pre && !ld_cnt;
  assign mask   = short_pre ? MASK_SHORT : MASK_FULL;                     // R3
  assign pre_nx = up ? pre_q + 1'b1 : pre_q - 1'b1;
  assign cnt_nx = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign pre_hit  = up ? ((pre_nx & mask) == '0) : ((pre_nx & mask) == mask);   // R4 R8
  assign cnt_wrap = up ? (cnt_nx == '0) : (cnt_nx == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ld_pre)    pre_q <= ld_val;                 // R2
      else if (step) pre_q <= pre_nx;
      if (ld_cnt)              cnt_q <= ld_val;
      else if (step && pre_hit) cnt_q <= cnt_nx;
      if (irq_clr)                                 irq_q <= 1'b0;   // R5 R6
      else if (step && pre_hit && cnt_wrap && en)  irq_q <= 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;

endmodule

// File: rtl/irq_prescale_counter.sv
module irq_prescale_counter
  import irqc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SHORT_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cyc_tick,
  input  logic              a12_level,
  input  logic              ppu_rd_tick,
  input  logic              ext_wr_tick,
  output logic              irq
);

  mode_t             mode;
  logic              en_q, ld_pre, ld_cnt, irq_clr, tick;
  logic [DATA_W-1:0] ld_val, cnt_q;
  logic [1:0]        mode_dir;

  assign mode_dir = mode.dir;

  irqc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .en(en_q), .ld_pre(ld_pre), .ld_cnt(ld_cnt),
    .ld_val(ld_val), .irq_clr(irq_clr)
  );

  irqc_src #(.SYNC_STAGES(SYNC_STAGES)) i_src (
    .clk(clk), .rst(rst), .src(mode.src), .cyc_tick(cyc_tick),
    .a12_level(a12_level), .ppu_rd_tick(ppu_rd_tick),
    .ext_wr_tick(ext_wr_tick), .tick(tick)
  );

  irqc_chain #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_chain (
    .clk(clk), .rst(rst), .tick(tick), .dir(mode.dir), .short_pre(mode.short_pre),
    .en(en_q), .ld_pre(ld_pre), .ld_cnt(ld_cnt), .ld_val(ld_val),
    .irq_clr(irq_clr), .cnt(cnt_q), .irq(irq)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic              en_q,
  input logic [1:0]        mode_dir,
  input logic [DATA_W-1:0] cnt_q
);

  logic page_hit, wr_ena0, wr_dis, wr_ens, wr_cnt, rst_d;

  assign page_hit = wr_en && (wr_addr[ADDR_W-1 -: 4] == 4'hC);
  assign wr_ena0  = page_hit && (wr_addr[2:0] == 3'd0) && !wr_data[0];
  assign wr_dis   = page_hit && (wr_addr[2:0] == 3'd2);
  assign wr_ens   = page_hit && (wr_addr[2:0] == 3'd3);
  assign wr_cnt   = page_hit && (wr_addr[2:0] == 3'd5);

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d == 1'b1) AST_RESET_IRQ_LOW: assert (irq == 1'b0);   // R10
  end

  AST_DISABLE_ACKS: assert property (@(posedge clk) disable iff (rst)
    wr_dis |=> !irq);                                             // R6
  AST_ENABLE_ZERO_ACKS: assert property (@(posedge clk) disable iff (rst)
    wr_ena0 |=> !irq);                                            // R5
  AST_STROBE_KEEPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_ens && irq) |=> irq);                                     // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_dis && !wr_ena0) |=> irq);                        // R4
  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> en_q);                                         // R4
  AST_HOLD_COUNTER: assert property (@(posedge clk) disable iff (rst)
    ((mode_dir == 2'b00 || mode_dir == 2'b11) && !wr_cnt) |=> $stable(cnt_q));  // R9

endmodule

bind irq_prescale_counter irqc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq(irq), .en_q(en_q), .mode_dir(mode_dir), .cnt_q(cnt_q)
);

// File: tb/test_irq_prescale_counter.sv
`timescale 1ns/1ps
module test_irq_prescale_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cyc_tick = 1'b0, a12_level = 1'b0, ppu_rd_tick = 1'b0, ext_wr_tick = 1'b0;
  logic        irq;

  always #2 clk = ~clk;   // 250 MHz

  irq_prescale_counter i_irq_prescale_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cyc_tick(cyc_tick), .a12_level(a12_level), .ppu_rd_tick(ppu_rd_tick),
    .ext_wr_tick(ext_wr_tick), .irq(irq)
  );

  typedef struct { logic val; string tag; } exp_t;
  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // step model of the requirements
  logic [7:0] m_pre = 0, m_cnt = 0, m_key = 0, m_mode = 0;
  logic       m_en = 0, m_irq = 0;

  task automatic push(string tag);
    exp_t e;
    e.val = m_irq; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model_tick();
    logic [7:0] mk;
    mk = m_mode[2] ? 8'h07 : 8'hFF;
    if (m_mode[7:6] == 2'b01) begin
      m_pre = m_pre + 1;
      if ((m_pre & mk) == 8'h00) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 8'h00 && m_en) m_irq = 1;
      end
    end else if (m_mode[7:6] == 2'b10) begin
      m_pre = m_pre - 1;
      if ((m_pre & mk) == mk) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 8'hFF && m_en) m_irq = 1;
      end
    end
  endtask

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    if (a[15:12] == 4'hC) begin
      case (a[2:0])
        3'd0: begin m_en = d[0]; if (!d[0]) m_irq = 0; end
        3'd1: m_mode = d;
        3'd2: begin m_en = 0; m_irq = 0; end
        3'd3: m_en = 1;
        3'd4: m_pre = d ^ m_key;
        3'd5: m_cnt = d ^ m_key;
        3'd6: m_key = d;
        default: ;
      endcase
    end
  endtask

  task automatic cpu_wr(logic [15:0] a, logic [7:0] d, string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_wr(a, d);
    push(tag);
  endtask

  task automatic pulse(int which, string tag);
    case (which)
      0: cyc_tick = 1;
      2: ppu_rd_tick = 1;
      default: ext_wr_tick = 1;
    endcase
    @(negedge clk);
    cyc_tick = 0; ppu_rd_tick = 0; ext_wr_tick = 0;
    if (which == int'(m_mode[1:0])) model_tick();
    push(tag);
  endtask

  task automatic a12_edge(int hold, string tag);
    a12_level = 1;
    repeat (4) @(negedge clk);
    if (m_mode[1:0] == 2'd1) model_tick();
    push(tag);
    for (int i = 0; i < hold; i++) begin @(negedge clk); push(tag); end
    a12_level = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); push(tag); end
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    push(tag);
  endtask

  // monitor: compares queued expectations after the outputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (irq !== e.val) begin
          errors++;
          $display("FAIL %s: irq=%b expected %b at %0t", e.tag, irq, e.val, $time);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle("R10");
    pulse(0, "R10");   // mode holds after reset: nothing moves

    // up count, 3-bit prescaler, CPU-cycle source
    cpu_wr(16'hC001, 8'h44, "R3");
    cpu_wr(16'hC006, 8'h00, "R2");
    cpu_wr(16'hC004, 8'h00, "R2");
    cpu_wr(16'hC005, 8'hFE, "R2");
    cpu_wr(16'hC003, 8'h01, "R7");
    repeat (16) pulse(0, "R4");
    repeat (3) idle("R4");
    cpu_wr(16'hC003, 8'h00, "R7");
    cpu_wr(16'hC002, 8'h00, "R6");
    cpu_wr(16'hC005, 8'hFF, "R6");
    repeat (8) pulse(0, "R6");

    // key applied to loads, 8-bit prescaler, enable via offset 0
    cpu_wr(16'hC006, 8'hA5, "R2");
    cpu_wr(16'hC001, 8'h40, "R3");
    cpu_wr(16'hC004, 8'h5A, "R2");
    cpu_wr(16'hC005, 8'h5A, "R2");
    cpu_wr(16'hC000, 8'h01, "R5");
    pulse(0, "R2");
    idle("R2");
    cpu_wr(16'hC000, 8'h00, "R5");

    // down count on graphics reads, and unselected sources ignored
    cpu_wr(16'hC006, 8'h00, "R8");
    cpu_wr(16'hC001, 8'h86, "R8");
    cpu_wr(16'hC004, 8'h00, "R8");
    cpu_wr(16'hC005, 8'h00, "R8");
    cpu_wr(16'hC003, 8'h01, "R8");
    pulse(0, "R1");
    pulse(3, "R1");
    a12_edge(0, "R1");
    pulse(2, "R8");
    idle("R8");
    cpu_wr(16'hC002, 8'h00, "R6");

    // hold directions
    cpu_wr(16'hC001, 8'hC4, "R9");
    cpu_wr(16'hC004, 8'hFE, "R9");
    cpu_wr(16'hC005, 8'hFF, "R9");
    cpu_wr(16'hC003, 8'h01, "R9");
    repeat (3) pulse(0, "R9");
    cpu_wr(16'hC001, 8'h04, "R9");
    repeat (3) pulse(0, "R9");
    cpu_wr(16'hC001, 8'h40, "R9");
    pulse(0, "R9");
    pulse(0, "R4");
    cpu_wr(16'hC002, 8'h00, "R6");

    // external write source
    cpu_wr(16'hC001, 8'h47, "R1");
    cpu_wr(16'hC004, 8'h07, "R1");
    cpu_wr(16'hC005, 8'hFF, "R1");
    cpu_wr(16'hC003, 8'h01, "R1");
    pulse(0, "R1");
    pulse(2, "R1");
    pulse(3, "R1");
    cpu_wr(16'hC002, 8'h00, "R6");

    // A12 rising edges only
    cpu_wr(16'hC001, 8'h45, "R11");
    cpu_wr(16'hC004, 8'h07, "R11");
    cpu_wr(16'hC005, 8'hFE, "R11");
    cpu_wr(16'hC003, 8'h01, "R11");
    a12_edge(12, "R11");
    for (int k = 0; k < 8; k++) a12_edge(0, "R11");
    cpu_wr(16'hC002, 8'h00, "R6");

    // decode through aliases, other pages and offset 7 ignored
    cpu_wr(16'hC7F1, 8'h40, "R12");
    cpu_wr(16'hCFFE, 8'h00, "R12");
    cpu_wr(16'hC00C, 8'hFF, "R12");
    cpu_wr(16'hC8AD, 8'hFF, "R12");
    cpu_wr(16'hCAB3, 8'h01, "R12");
    cpu_wr(16'hD005, 8'h00, "R12");
    cpu_wr(16'h4005, 8'h00, "R12");
    cpu_wr(16'hC007, 8'h00, "R12");
    pulse(0, "R12");
    idle("R12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule